// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that completes one instruction per clock cycle. It follows a load/store discipline: only the word load and the word store touch data memory, and every other instruction works on the 32-entry register file. It supports nine instructions: add, sub, slt and jr in the register format, lw, sw, beq and bne in the immediate format, and j in the jump format.

Each cycle, the core presents the program counter on a combinational instruction-fetch port. It decodes the returned word, reads two source registers and computes an ALU or address result. It then selects the next program counter from the sequential, branch, jump and register-indirect candidates. The data port reads combinationally. A store is committed by the memory at the next rising edge. A register write also lands on that edge, so a value loaded from memory can be used by the very next instruction. This includes an address fetched from a jump table and consumed at once by a register-indirect jump.

A debug port reads any register combinationally, so a test can inspect architectural state without running extra instructions.

Top module: `rcore_top`

## Requirements
- R1: While rst_n is low, and after its release until the first rising edge, imem_addr equals RESET_PC (default 0) and every register reads 0 through the debug port.
- R2: Register 0 always reads 0, and any write that targets it is discarded.
- R3: With opcode [31:26]=0, funct [5:0]=32 (add) writes rs+rt, and funct 34 (sub) writes rs-rt, into the register named by [15:11], modulo 2^32. The rs field is [25:21] and the rt field is [20:16].
- R4: With opcode 0 and funct 42 (slt), the core writes 1 into rd when rs is less than rt as signed 32-bit numbers, and writes 0 otherwise.
- R5: Opcode 35 (lw) drives dmem_addr = rs + sign-extended [15:0] and writes dmem_rdata into rt.
- R6: Opcode 43 (sw) raises dmem_we for that cycle, with dmem_addr = rs + sign-extended [15:0] and dmem_wdata = rt. No other instruction raises dmem_we.
- R7: Every instruction that is not a taken branch, j or jr advances the PC by 4.
- R8: Opcode 4 (beq) and opcode 5 (bne) compare rs with rt. When beq finds them equal, or bne finds them different, the next PC is PC+4 plus the sign-extended offset shifted left by 2. Otherwise the next PC is PC+4.
- R9: Opcode 2 (j) sets the PC to bits [31:28] of PC+4, followed by the 26-bit index [25:0], followed by two zero bits.
- R10: With opcode 0 and funct 8 (jr), the next PC is the value of rs with bits [1:0] cleared.
- R11: An unsupported opcode, or an unsupported funct under opcode 0, writes no register, leaves dmem_we low and advances the PC by 4.
- R12: dbg_data shows the current content of the register selected by dbg_sel within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed by memory at the next rising edge |
| dmem_rdata | input | 32 | Word at dmem_addr, same cycle |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Content of register dbg_sel |

## Verification
Two functions share one edge in this core: the register write-back of one instruction, and the operand read of the next. The sharpest case is a load that fetches a jump-table entry, followed directly by a register-indirect jump through that register. The switch program provokes it on every in-range selector. It is judged by whether the PC lands on the case body named by the table, which the bench confirms through the stored result. The same edge sharing is provoked in the randomized arithmetic sequences, where destinations are often reused as sources in the next instruction. There it is judged against a bench model that applies the instructions strictly in order.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;

    localparam logic [5:0] OPC_SPECIAL = 6'd0;
    localparam logic [5:0] OPC_J       = 6'd2;
    localparam logic [5:0] OPC_BEQ     = 6'd4;
    localparam logic [5:0] OPC_BNE     = 6'd5;
    localparam logic [5:0] OPC_LW      = 6'd35;
    localparam logic [5:0] OPC_SW      = 6'd43;

    localparam logic [5:0] FN_JR  = 6'd8;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT
    } alu_op_e;

    typedef enum logic [2:0] {
        PCS_SEQ,
        PCS_BEQ,
        PCS_BNE,
        PCS_JUMP,
        PCS_REG
    } pc_src_e;

    typedef enum logic [1:0] {
        WB_NONE,
        WB_ALU,
        WB_MEM
    } wb_src_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    use_imm;
        wb_src_e wb;
        logic    dst_rt;
        logic    mem_wr;
        pc_src_e pc_src;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '{
        alu_op:  ALU_ADD,
        use_imm: 1'b0,
        wb:      WB_NONE,
        dst_rt:  1'b0,
        mem_wr:  1'b0,
        pc_src:  PCS_SEQ
    };
endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
    import rcore_pkg::*;
(
    input  logic [XLEN-1:0]   instr,
    output ctrl_t             ctrl,
    output logic [RIDX_W-1:0] rs_idx,
    output logic [RIDX_W-1:0] rt_idx,
    output logic [RIDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]   imm_sx,
    output logic [25:0]       jidx
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IMM_W = 16;

    logic [5:0] opc;
    logic [5:0] fn;

    assign opc    = instr[31:26];
    assign fn     = instr[5:0];
    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];
    assign jidx   = instr[25:0];
    assign imm_sx = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};

    always_comb begin
        ctrl = CTRL_NOP;
        unique case (opc)
            OPC_SPECIAL: begin
                unique case (fn)
                    FN_ADD: begin
                        ctrl.alu_op = ALU_ADD;
                        ctrl.wb     = WB_ALU;
                    end
                    FN_SUB: begin
                        ctrl.alu_op = ALU_SUB;
                        ctrl.wb     = WB_ALU;
                    end
                    FN_SLT: begin
                        ctrl.alu_op = ALU_SLT;
                        ctrl.wb     = WB_ALU;
                    end
                    FN_JR: begin
                        ctrl.pc_src = PCS_REG;
                    end
                    default: begin
                        ctrl = CTRL_NOP;
                    end
                endcase
            end
            OPC_LW: begin
                ctrl.use_imm = 1'b1;
                ctrl.wb      = WB_MEM;
                ctrl.dst_rt  = 1'b1;
            end
            OPC_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OPC_BEQ: ctrl.pc_src = PCS_BEQ;
            OPC_BNE: ctrl.pc_src = PCS_BNE;
            OPC_J:   ctrl.pc_src = PCS_JUMP;
            default: ctrl = CTRL_NOP;
        endcase
    end
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [AW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] dbg_idx,
    output logic [W-1:0]  dbg_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NREGS = 1 << AW;

    // Entry 0 has no storage: it is the constant zero of every read mux.
    logic [W-1:0] regs [1:NREGS-1];

    for (genvar g = 1; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_idx == AW'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    always_comb begin
        ra_data  = '0;
        rb_data  = '0;
        dbg_data = '0;
        for (int k = 1; k < NREGS; k++) begin
            if (ra_idx == AW'(k))  ra_data  = regs[k];
            if (rb_idx == AW'(k))  rb_data  = regs[k];
            if (dbg_idx == AW'(k)) dbg_data = regs[k];
        end
    end
endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
    import rcore_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/rcore_nextpc.sv
module rcore_nextpc
    import rcore_pkg::*;
(
    input  logic [XLEN-1:0] pc_cur,
    input  pc_src_e         pc_src,
    input  logic [XLEN-1:0] imm_sx,
    input  logic [25:0]     jidx,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    output logic [XLEN-1:0] pc_next
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] j_tgt;
    logic [XLEN-1:0] reg_tgt;
    logic            same;

    assign pc_plus4 = pc_cur + XLEN'(4);
    assign br_tgt   = pc_plus4 + (imm_sx << 2);
    assign j_tgt    = {pc_plus4[XLEN-1:28], jidx, 2'b00};
    assign reg_tgt  = {rs_val[XLEN-1:2], 2'b00};
    assign same     = (rs_val == rt_val);

    always_comb begin
        unique case (pc_src)
            PCS_SEQ:  pc_next = pc_plus4;
            PCS_BEQ:  pc_next = same ? br_tgt : pc_plus4;
            PCS_BNE:  pc_next = same ? pc_plus4 : br_tgt;
            PCS_JUMP: pc_next = j_tgt;
            PCS_REG:  pc_next = reg_tgt;
            default:  pc_next = pc_plus4;
        endcase
    end
endmodule

// File: rtl/rcore_top.sv
module rcore_top
    import rcore_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata,
    input  logic [4:0]  dbg_sel,
    output logic [31:0] dbg_data
);
    timeunit 1ns;
    timeprecision 1ps;

    ctrl_t             ctrl;
    logic [RIDX_W-1:0] rs_idx;
    logic [RIDX_W-1:0] rt_idx;
    logic [RIDX_W-1:0] rd_idx;
    logic [XLEN-1:0]   imm_sx;
    logic [25:0]       jidx;
    logic [XLEN-1:0]   rs_val;
    logic [XLEN-1:0]   rt_val;
    logic [XLEN-1:0]   alu_b;
    logic [XLEN-1:0]   alu_y;
    logic [XLEN-1:0]   pc_q;
    logic [XLEN-1:0]   pc_next;
    logic              wr_en;
    logic [RIDX_W-1:0] wr_idx;
    logic [XLEN-1:0]   wr_data;

    rcore_decode u_decode (
        .instr  (imem_data),
        .ctrl   (ctrl),
        .rs_idx (rs_idx),
        .rt_idx (rt_idx),
        .rd_idx (rd_idx),
        .imm_sx (imm_sx),
        .jidx   (jidx)
    );

    rcore_regfile #(
        .W  (XLEN),
        .AW (RIDX_W)
    ) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_idx   (rs_idx),
        .ra_data  (rs_val),
        .rb_idx   (rt_idx),
        .rb_data  (rt_val),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .dbg_idx  (dbg_sel),
        .dbg_data (dbg_data)
    );

    assign alu_b = ctrl.use_imm ? imm_sx : rt_val;

    rcore_alu #(
        .W (XLEN)
    ) u_alu (
        .a  (rs_val),
        .b  (alu_b),
        .op (ctrl.alu_op),
        .y  (alu_y)
    );

    rcore_nextpc u_nextpc (
        .pc_cur  (pc_q),
        .pc_src  (ctrl.pc_src),
        .imm_sx  (imm_sx),
        .jidx    (jidx),
        .rs_val  (rs_val),
        .rt_val  (rt_val),
        .pc_next (pc_next)
    );

    // Write-back select: loads take the memory word into rt, ALU ops into rd.
    assign wr_en   = (ctrl.wb != WB_NONE);
    assign wr_idx  = ctrl.dst_rt ? rt_idx : rd_idx;
    assign wr_data = (ctrl.wb == WB_MEM) ? dmem_rdata : alu_y;

    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.mem_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign imem_addr = pc_q;
endmodule

// File: rtl/rcore_checker.sv
module rcore_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] imem_addr,
    input logic [31:0] imem_data,
    input logic        dmem_we,
    input logic [4:0]  dbg_sel,
    input logic [31:0] dbg_data
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [5:0]  c_opc;
    logic [5:0]  c_fn;
    logic        c_redirect;
    logic        c_branch;
    logic [31:0] c_pc4;
    logic [31:0] c_jexp;
    logic [31:0] c_bexp;

    assign c_opc      = imem_data[31:26];
    assign c_fn       = imem_data[5:0];
    assign c_branch   = (c_opc == 6'd4) || (c_opc == 6'd5);
    assign c_redirect = c_branch || (c_opc == 6'd2) ||
                        ((c_opc == 6'd0) && (c_fn == 6'd8));
    assign c_pc4      = imem_addr + 32'd4;
    assign c_jexp     = {c_pc4[31:28], imem_data[25:0], 2'b00};
    assign c_bexp     = c_pc4 + {{14{imem_data[15]}}, imem_data[15:0], 2'b00};

    AST_RESET_PC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (imem_addr == 32'd0)); // R1

    AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_sel == 5'd0) |-> (dbg_data == 32'd0)); // R2

    AST_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (c_opc == 6'd43)); // R6

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !c_redirect |=> (imem_addr == $past(imem_addr) + 32'd4)); // R7

    AST_BRANCH_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        c_branch |=> ((imem_addr == $past(c_pc4)) || (imem_addr == $past(c_bexp)))); // R8

    AST_JUMP_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        (c_opc == 6'd2) |=> (imem_addr == $past(c_jexp))); // R9

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        imem_addr[1:0] == 2'b00); // R10
endmodule

bind rcore_top rcore_checker u_rcore_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .dmem_we   (dmem_we),
    .dbg_sel   (dbg_sel),
    .dbg_data  (dbg_data)
);

// File: tb/rcore_top_bench.sv
module rcore_top_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr;
    logic [31:0] imem_data;
    logic [31:0] dmem_addr;
    logic [31:0] dmem_wdata;
    logic        dmem_we;
    logic [31:0] dmem_rdata;
    logic [4:0]  dbg_sel = 5'd0;
    logic [31:0] dbg_data;

    logic [31:0] imem [256];
    logic [31:0] dmem [256];

    int n_run  = 0;
    int n_fail = 0;

    // 50 MHz: 20 ns period
    always #10 clk = ~clk;

    assign imem_data  = imem[imem_addr[9:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    rcore_top u_rcore_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .dbg_sel    (dbg_sel),
        .dbg_data   (dbg_data)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] opc, input int rs, input int rt, input int off);
        return {opc, 5'(rs), 5'(rt), 16'(off)};
    endfunction

    function automatic logic [31:0] enc_j(input int idx);
        return {6'd2, 26'(idx)};
    endfunction

    function automatic logic [31:0] alu_ref(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
        case (fn)
            6'd32:   return a + b;
            6'd34:   return a - b;
            6'd42:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] switch_ref(input int k, input logic [31:0] g, input logic [31:0] h,
                                               input logic [31:0] i, input logic [31:0] j);
        case (k)
            0:       return i + j;
            1:       return g + h;
            2:       return g - h;
            3:       return i - j;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] pick_val();
        case ($urandom % 5)
            0:       return 32'h7FFF_FFFF;
            1:       return 32'h8000_0000;
            2:       return 32'hFFFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic dbg_read(input int idx, output logic [31:0] val);
        dbg_sel = 5'(idx);
        #1;
        val = dbg_data;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_mems();
        for (int a = 0; a < 256; a++) begin
            imem[a] = 32'd0;
            dmem[a] = 32'd0;
        end
    endtask

    // Releases reset, then steps until the PC reaches halt_pc; stores are
    // committed by this model memory ahead of the next rising edge.
    task automatic run_prog(input logic [31:0] halt_pc, input int limit, input string req);
        int cyc = 0;
        @(negedge clk);
        rst_n = 1'b1;
        while ((imem_addr != halt_pc) && (cyc < limit)) begin
            if (dmem_we) dmem[dmem_addr[9:2]] = dmem_wdata;
            @(negedge clk);
            cyc++;
        end
        chk(req, "program reached halt address", imem_addr, halt_pc);
    endtask

    task automatic load_switch_prog();
        imem[0]  = enc_i(6'd35, 0, 5, 0);
        imem[1]  = enc_i(6'd35, 0, 1, 4);
        imem[2]  = enc_i(6'd35, 0, 2, 8);
        imem[3]  = enc_i(6'd35, 0, 3, 12);
        imem[4]  = enc_i(6'd35, 0, 4, 16);
        imem[5]  = enc_i(6'd35, 0, 6, 20);
        imem[6]  = enc_i(6'd35, 0, 7, 24);
        imem[7]  = enc_r(5, 0, 8, 6'd42);
        imem[8]  = enc_i(6'd5, 8, 0, 14);
        imem[9]  = enc_r(5, 6, 8, 6'd42);
        imem[10] = enc_i(6'd4, 8, 0, 12);
        imem[11] = enc_r(5, 5, 9, 6'd32);
        imem[12] = enc_r(9, 9, 9, 6'd32);
        imem[13] = enc_r(9, 7, 9, 6'd32);
        imem[14] = enc_i(6'd35, 9, 10, 0);
        imem[15] = enc_r(10, 0, 0, 6'd8);
        imem[16] = enc_r(3, 4, 16, 6'd32);
        imem[17] = enc_j(23);
        imem[18] = enc_r(1, 2, 16, 6'd32);
        imem[19] = enc_j(23);
        imem[20] = enc_r(1, 2, 16, 6'd34);
        imem[21] = enc_j(23);
        imem[22] = enc_r(3, 4, 16, 6'd34);
        imem[23] = enc_i(6'd43, 0, 16, 28);
        imem[24] = enc_j(24);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] g;
        logic [31:0] h;
        logic [31:0] ii;
        logic [31:0] jj;
        logic [31:0] exp_r [16];
        int ks [6] = '{0, 1, 2, 3, -1, 4};
        void'($urandom(32'd7331));

        // ---------------- jump-table switch (R10, R8, R9, R5, R6, R3, R4)
        foreach (ks[n]) begin
            hold_reset();
            clear_mems();
            load_switch_prog();
            g  = pick_val();
            h  = pick_val();
            ii = pick_val();
            jj = pick_val();
            dmem[0] = 32'(ks[n]);
            dmem[1] = g;
            dmem[2] = h;
            dmem[3] = ii;
            dmem[4] = jj;
            dmem[5] = 32'd4;
            dmem[6] = 32'd64;
            dmem[7] = 32'hFFFF_FFFF;
            dmem[16] = 32'd64;
            dmem[17] = 32'd72;
            dmem[18] = 32'd80;
            dmem[19] = 32'd88;
            run_prog(32'd96, 200, "R10");
            dbg_read(16, v);
            chk("R10", $sformatf("switch k=%0d case result", ks[n]), v, switch_ref(ks[n], g, h, ii, jj));
            chk("R6", $sformatf("switch k=%0d stored word", ks[n]), dmem[7], switch_ref(ks[n], g, h, ii, jj));
            dbg_read(10, v);
            if (ks[n] >= 0 && ks[n] < 4)
                chk("R5", "table entry loaded into r10", v, 32'd64 + 32'(8 * ks[n]));
        end

        // ---------------- reset clears state (R1)
        hold_reset();
        chk("R1", "PC during reset", imem_addr, 32'd0);
        for (int r = 0; r < 32; r++) begin
            dbg_read(r, v);
            chk("R1", $sformatf("register %0d during reset", r), v, 32'd0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "PC after release before first edge", imem_addr, 32'd0);

        // ---------------- array scan loop (R8 bne/j, R5)
        for (int t = 0; t < 4; t++) begin
            int nm;
            int stp;
            hold_reset();
            clear_mems();
            nm  = (t == 0) ? 0 : int'($urandom % 18);
            stp = 1 + int'($urandom % 3);
            imem[0]  = enc_i(6'd35, 0, 19, 36);
            imem[1]  = enc_i(6'd35, 0, 20, 40);
            imem[2]  = enc_i(6'd35, 0, 21, 44);
            imem[3]  = enc_r(0, 0, 22, 6'd32);
            imem[4]  = enc_r(22, 22, 9, 6'd32);
            imem[5]  = enc_r(9, 9, 9, 6'd32);
            imem[6]  = enc_r(9, 19, 9, 6'd32);
            imem[7]  = enc_i(6'd35, 9, 8, 0);
            imem[8]  = enc_r(22, 21, 22, 6'd32);
            imem[9]  = enc_i(6'd5, 8, 20, 1);
            imem[10] = enc_j(4);
            imem[11] = enc_i(6'd43, 0, 22, 48);
            imem[12] = enc_j(12);
            dmem[9]  = 32'd128;
            dmem[10] = 32'd7;
            dmem[11] = 32'(stp);
            for (int a = 32; a < 96; a++) dmem[a] = 32'd7;
            dmem[32 + nm * stp] = 32'd8;
            run_prog(32'd48, 2000, "R8");
            chk("R8", $sformatf("scan n=%0d step=%0d final index", nm, stp), dmem[12], 32'((nm + 1) * stp));
        end

        // ---------------- directed corners (R2, R4, R5, R6, R8, R10, R11, R3)
        hold_reset();
        clear_mems();
        imem[0]  = enc_i(6'd35, 0, 1, 0);
        imem[1]  = enc_i(6'd35, 0, 2, 4);
        imem[2]  = enc_r(1, 2, 3, 6'd42);
        imem[3]  = enc_r(2, 1, 4, 6'd42);
        imem[4]  = enc_r(2, 1, 5, 6'd34);
        imem[5]  = enc_r(2, 2, 0, 6'd32);
        imem[6]  = enc_i(6'd35, 0, 6, 8);
        imem[7]  = enc_i(6'd35, 6, 7, -4);
        imem[8]  = enc_i(6'd43, 6, 2, -8);
        imem[9]  = 32'hFC08_FFFF;
        imem[10] = enc_r(2, 2, 9, 6'd63);
        imem[11] = enc_i(6'd4, 1, 2, 5);
        imem[12] = enc_r(2, 2, 10, 6'd32);
        imem[13] = enc_i(6'd35, 0, 11, 12);
        imem[14] = enc_r(11, 0, 0, 6'd8);
        imem[15] = enc_r(2, 2, 12, 6'd32);
        imem[16] = enc_i(6'd5, 1, 2, 1);
        imem[17] = enc_r(2, 2, 13, 6'd32);
        imem[18] = enc_r(2, 1, 14, 6'd32);
        imem[19] = enc_j(19);
        dmem[0]  = 32'h8000_0000;
        dmem[1]  = 32'd5;
        dmem[2]  = 32'd100;
        dmem[3]  = 32'd67;
        dmem[23] = 32'd0;
        dmem[24] = 32'h1234_5678;
        run_prog(32'd76, 200, "R11");
        dbg_read(3, v);  chk("R4", "slt negative < positive", v, 32'd1);
        dbg_read(4, v);  chk("R4", "slt positive < negative", v, 32'd0);
        dbg_read(5, v);  chk("R3", "sub wraps", v, 32'h8000_0005);
        dbg_read(0, v);  chk("R2", "write to r0 discarded", v, 32'd0);
        dbg_read(7, v);  chk("R5", "load with negative offset", v, 32'h1234_5678);
        chk("R6", "store with negative offset", dmem[23], 32'd5);
        dbg_read(8, v);  chk("R11", "unknown opcode wrote no register", v, 32'd0);
        dbg_read(9, v);  chk("R11", "unknown funct wrote no register", v, 32'd0);
        dbg_read(10, v); chk("R8", "untaken beq falls through", v, 32'd10);
        dbg_read(12, v); chk("R10", "jr skips next word, low bits cleared", v, 32'd0);
        dbg_read(13, v); chk("R8", "taken bne skips one word", v, 32'd0);
        dbg_read(14, v); chk("R3", "add at branch target", v, 32'h8000_0005);

        // ---------------- random arithmetic sequences (R3, R4, R2, R12)
        for (int rnd = 0; rnd < 6; rnd++) begin
            hold_reset();
            clear_mems();
            for (int q = 0; q < 16; q++) exp_r[q] = 32'd0;
            for (int q = 1; q < 8; q++) begin
                dmem[q - 1] = pick_val();
                exp_r[q]    = dmem[q - 1];
                imem[q - 1] = enc_i(6'd35, 0, q, 4 * (q - 1));
            end
            for (int s = 7; s < 47; s++) begin
                int rd;
                int rs;
                int rt;
                logic [5:0] fn;
                rd = int'($urandom % 16);
                rs = int'($urandom % 16);
                rt = int'($urandom % 16);
                case ($urandom % 3)
                    0:       fn = 6'd32;
                    1:       fn = 6'd34;
                    default: fn = 6'd42;
                endcase
                imem[s] = enc_r(rs, rt, rd, fn);
                if (rd != 0) exp_r[rd] = alu_ref(fn, exp_r[rs], exp_r[rt]);
            end
            imem[47] = enc_j(47);
            run_prog(32'd188, 200, "R7");
            for (int q = 0; q < 16; q++) begin
                dbg_read(q, v);
                chk((q == 0) ? "R2" : "R12", $sformatf("random round %0d register %0d", rnd, q), v, exp_r[q]);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule